// File: doc/BRIEF.md
# Dual Reloadable Down-Counter Timer

This peripheral holds two independent 32-bit down-counters behind a small synchronous register bus. Each counter has a value register, which loads the counter as soon as it is written and reads back the live count, and a reload register that supplies the start value after each expiry. A shared control word switches each counter on, chooses whether it restarts from its reload value or stops after one expiry, and picks its tick source. The tick source is either an external reference-tick enable, or the fabric clock divided by two to the power of a 3-bit exponent.

When a counter passes zero on a tick it raises a sticky event flag, and each flag drives its own interrupt pin. Software clears a flag by writing a 0 to its bit in the event register; a 1 leaves the flag as it is. A free-running counter with an all-ones reload wraps forever, so its bitwise inverse serves as a rising timestamp. Periodic mode gives a tick every R+1 counts for a reload value R, and one-shot mode gives a single event per programming.

Top module: `dtmr_top`

## Requirements
- R1: After reset the control word, the event register, both reload registers and both counters read 0, and both interrupt outputs are low.
- R2: Byte addresses: control 0x00, events 0x04, counter 0 reload 0x10, counter 0 value 0x14, counter 1 reload 0x18, counter 1 value 0x1C. Any other address reads 0. In the control word only bits 0..3, 11, 12 and 19..24 are stored (readback mask 0x01F8180F); other bits read 0.
- R3: A write to a value register loads the counter at that clock edge, overriding any tick in the same cycle. A counter that gets no tick holds its value.
- R4: Counter n is enabled by control bit 2n. When its reference-select bit (bit 11+n) is 0, it advances once every 2^D clock cycles, where D is the 3-bit field at bits 19+3n..21+3n. The divider restarts when the enable is cleared, so the first tick comes on the 2^D-th enabled cycle.
- R5: When the reference-select bit is 1, an enabled counter advances on every cycle in which the `ref_tick` input is high.
- R6: With reload-enable (bit 2n+1) set, a tick at count 0 is an expiry that loads the reload value, so reload R gives a period of R+1 ticks. A write to the reload register affects only the next reload.
- R7: With reload-enable clear, a tick at count 0 expires once after a value write. The counter then stays at 0 and makes no further event until the value register is written again.
- R8: Counter 0's event flag is bit 0 and counter 1's is bit 8 of the event register. An expiry sets the flag at the edge of the expiry tick. A write clears each flag whose bit is 0 and keeps each flag whose bit is 1. A set and a clear in the same cycle leave the flag set.
- R9: `irq_t0` and `irq_t1` always equal the event flags of counter 0 and counter 1.
- R10: The two counters are independent: writes and ticks of one never change the count of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference tick enable, one pulse per tick |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_t0 | output | 1 | Event flag of counter 0 |
| irq_t1 | output | 1 | Event flag of counter 1 |

## Verification
On every cycle the assertions check that a counter without a tick or a load keeps its count and that a periodic expiry lands exactly on the prior reload value. They also check that an idle one-shot counter cannot expire, that a divider starting from enable does not tick early, that an expiry always leaves its flag set, and that an uncontested clear takes effect. Only the bench scenarios show the timing as a whole: the exact tick rates for several divider exponents, reference-tick counting, the R+1 period, a reload write that waits for the next expiry, one-shot silence after firing, and masked flag clears against a flag that is set every cycle.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  localparam int unsigned NUM_CH  = 2;
  localparam int unsigned DIV_W   = 3;
  localparam int unsigned PSC_W   = (1 << DIV_W) - 1;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_EVT  = 8'h04;

  localparam logic [31:0] CTRL_KEEP = 32'h01F8_180F;

  function automatic int en_pos(input int ch);
    return 2 * ch;
  endfunction

  function automatic int rel_pos(input int ch);
    return 2 * ch + 1;
  endfunction

  function automatic int ref_pos(input int ch);
    return 11 + ch;
  endfunction

  function automatic int div_pos(input int ch);
    return 19 + 3 * ch;
  endfunction

  function automatic int flag_pos(input int ch);
    return 8 * ch;
  endfunction

  function automatic logic [7:0] reload_off(input int ch);
    return 8'(8'h10 + 8 * ch);
  endfunction

  function automatic logic [7:0] value_off(input int ch);
    return 8'(8'h14 + 8 * ch);
  endfunction

  // Low D bits set: divider period 2^D minus one.
  function automatic logic [PSC_W-1:0] psc_mask(input logic [DIV_W-1:0] d);
    logic [PSC_W-1:0] m;
    for (int i = 0; i < PSC_W; i++) m[i] = (i < int'(d));
    return m;
  endfunction

endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler
  import dtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             refsel,
  input  logic             ref_tick,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] mask;
  logic             psc_hit;

  assign mask    = psc_mask(div);
  assign psc_hit = ((psc_q & mask) == mask);
  assign tick    = en & (refsel ? ref_tick : psc_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      psc_q <= '0;
    else if (!en)    psc_q <= '0;
    else if (psc_hit) psc_q <= '0;
    else             psc_q <= psc_q + 1'b1;
  end

  // First enabled cycle of a divided source ticks only for divide-by-one.
  p_first_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en) && !refsel && (div != '0)) |-> !tick)
    else $error("p_first_tick_r4");

endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reload_en,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] reload_val,
  output logic [DATA_W-1:0] count,
  output logic              expire
);

  logic armed_q;
  logic at_zero;

  assign at_zero = (count == '0);
  assign expire  = tick & at_zero & (reload_en | armed_q) & ~load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      count   <= load_val;
      armed_q <= 1'b1;
    end else if (expire) begin
      count <= reload_en ? reload_val : '0;
      if (!reload_en) armed_q <= 1'b0;
    end else if (tick && !at_zero) begin
      count <= count - 1'b1;
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count))
    else $error("p_hold_r3");

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && reload_en) |=> (count == $past(reload_val)))
    else $error("p_reload_r6");

  p_oneshot_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !reload_en && !load) |-> !expire)
    else $error("p_oneshot_idle_r7");

endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
  import dtmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_t0,
  output logic              irq_t1
);

  logic [DATA_W-1:0] ctrl_q;
  logic [NUM_CH-1:0] flag_q;
  logic [NUM_CH-1:0] tick_w;
  logic [NUM_CH-1:0] expire_w;
  logic [NUM_CH-1:0] load_w;
  logic [NUM_CH-1:0] clr_req;
  logic [DATA_W-1:0] reload_q [NUM_CH];
  logic [DATA_W-1:0] count_w  [NUM_CH];

  logic wr_ctrl, wr_evt;
  assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_evt  = bus_we && (bus_addr == ADDR_W'(OFF_EVT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata & DATA_W'(CTRL_KEEP);
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int EN_B  = en_pos(i);
    localparam int REL_B = rel_pos(i);
    localparam int REF_B = ref_pos(i);
    localparam int DIV_B = div_pos(i);
    localparam int FLG_B = flag_pos(i);

    logic wr_reload;
    assign wr_reload  = bus_we && (bus_addr == ADDR_W'(reload_off(i)));
    assign load_w[i]  = bus_we && (bus_addr == ADDR_W'(value_off(i)));
    assign clr_req[i] = wr_evt && !bus_wdata[FLG_B];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         reload_q[i] <= '0;
      else if (wr_reload) reload_q[i] <= bus_wdata;
    end

    dtmr_prescaler u_psc (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctrl_q[EN_B]),
      .refsel   (ctrl_q[REF_B]),
      .ref_tick (ref_tick),
      .div      (ctrl_q[DIV_B +: DIV_W]),
      .tick     (tick_w[i])
    );

    dtmr_channel #(.DATA_W(DATA_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick_w[i]),
      .reload_en  (ctrl_q[REL_B]),
      .load       (load_w[i]),
      .load_val   (bus_wdata),
      .reload_val (reload_q[i]),
      .count      (count_w[i]),
      .expire     (expire_w[i])
    );

    // Hardware set has priority over a software clear.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flag_q[i] <= 1'b0;
      else if (expire_w[i])  flag_q[i] <= 1'b1;
      else if (clr_req[i])   flag_q[i] <= 1'b0;
    end

    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      expire_w[i] |=> flag_q[i])
      else $error("p_flag_set_r8");

    p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req[i] && !expire_w[i]) |=> !flag_q[i])
      else $error("p_flag_clr_r8");
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_CTRL)) bus_rdata = ctrl_q;
    if (bus_addr == ADDR_W'(OFF_EVT)) begin
      for (int i = 0; i < NUM_CH; i++) bus_rdata[flag_pos(i)] = flag_q[i];
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(reload_off(i))) bus_rdata = reload_q[i];
      if (bus_addr == ADDR_W'(value_off(i)))  bus_rdata = count_w[i];
    end
  end

  assign irq_t0 = flag_q[0];
  assign irq_t1 = flag_q[1];

  p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w[0] |=> irq_t0)
    else $error("p_irq_follow_r9");

endmodule

// File: tb/dtmr_top_test.sv
module dtmr_top_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_tick;
  logic        we;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq0, irq1;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dtmr_top uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .irq_t0(irq0), .irq_t1(irq1)
  );

  // Behavioural reference model
  logic [31:0] m_ctrl;
  logic [31:0] m_cnt [2];
  logic [31:0] m_rel [2];
  bit          m_arm [2];
  bit          m_flag[2];
  int          m_phase[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0;
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_rel[c] = 0; m_arm[c] = 0; m_flag[c] = 0; m_phase[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit en, rl, rs, tk, ex;
        int dv;
        en = m_ctrl[2*c];
        rl = m_ctrl[2*c+1];
        rs = m_ctrl[11+c];
        dv = int'(m_ctrl[19+3*c +: 3]);
        tk = en && (rs ? ref_tick : (((m_phase[c] + 1) % (1 << dv)) == 0));
        ex = 0;
        if (we && addr == 8'(8'h14 + 8*c)) begin
          m_cnt[c] = wdata; m_arm[c] = 1;
        end else if (tk) begin
          if (m_cnt[c] != 0) m_cnt[c] = m_cnt[c] - 1;
          else if (rl || m_arm[c]) begin
            ex = 1;
            m_cnt[c] = rl ? m_rel[c] : 0;
            if (!rl) m_arm[c] = 0;
          end
        end
        m_phase[c] = en ? m_phase[c] + 1 : 0;
        if (we && addr == 8'h04 && !wdata[8*c]) m_flag[c] = 0;
        if (ex) m_flag[c] = 1;
        if (we && addr == 8'(8'h10 + 8*c)) m_rel[c] = wdata;
      end
      if (we && addr == 8'h00) m_ctrl = wdata & 32'h01F8180F;
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_ctrl;
      8'h04: return {23'd0, m_flag[1], 7'd0, m_flag[0]};
      8'h10: return m_rel[0];
      8'h14: return m_cnt[0];
      8'h18: return m_rel[1];
      8'h1C: return m_cnt[1];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04: return "R8";
      8'h14, 8'h1C: return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic compare_now();
    if (rst_n) begin
      check(irq0 == m_flag[0], "R9", 32'(irq0), 32'(m_flag[0]));
      check(irq1 == m_flag[1], "R9", 32'(irq1), 32'(m_flag[1]));
      check(rdata == m_read(addr), tag_of(addr), rdata, m_read(addr));
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #(CLK_PERIOD / 4);
    compare_now();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d;
    cyc();
    we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic wait_irq0(input int lim, output int n);
    n = 0;
    while (!irq0 && n < lim) begin cyc(); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, v;
    int n, e;
    rst_n = 0; we = 0; addr = 0; wdata = 0; ref_tick = 0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD / 4);
    rst_n = 1;
    cyc();

    // R1: reset values
    foreach (v[i]) begin end
    for (int k = 0; k < 6; k++) begin
      logic [7:0] ra;
      ra = (k < 2) ? 8'(4*k) : 8'(8'h10 + 4*(k-2));
      rd(ra, a);
      check(a == 0, "R1", a, 0);
    end
    check(!irq0 && !irq1, "R1", {30'd0, irq1, irq0}, 0);

    // R2: control readback mask and unmapped address
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, a);
    check(a == 32'h01F8180F, "R2", a, 32'h01F8180F);
    wr(8'h00, 0);
    rd(8'h08, a);
    check(a == 0, "R2", a, 0);

    // R3: load while disabled, then hold
    wr(8'h14, 100);
    idle(10);
    rd(8'h14, a);
    check(a == 100, "R3", a, 100);

    // R4: divide by 8 on counter 0
    wr(8'h14, 1000);
    wr(8'h00, 32'h1 | (32'd3 << 19));
    idle(20);
    rd(8'h14, a);
    idle(64);
    rd(8'h14, b);
    check(a - b == 8, "R4", a - b, 8);

    // R4: divide by 1
    wr(8'h00, 32'h1);
    rd(8'h14, a);
    idle(10);
    rd(8'h14, b);
    check(a - b == 10, "R4", a - b, 10);

    // R10: counter 1 at divide by 32 while counter 0 is reloaded
    wr(8'h00, 0);
    wr(8'h1C, 5000);
    wr(8'h00, 32'h4 | (32'd5 << 22));
    rd(8'h1C, a);
    for (int k = 0; k < 8; k++) begin
      wr(8'h14, 32'(k * 7));
      idle(7);
    end
    rd(8'h1C, b);
    check(a - b == 2, "R10", a - b, 2);
    check(a - b == 2, "R4", a - b, 2);

    // R5: reference tick source on counter 1
    wr(8'h00, 32'h4 | 32'h1000);
    rd(8'h1C, a);
    for (int k = 0; k < 30; k++) begin
      ref_tick = (k % 3 == 0);
      cyc();
    end
    ref_tick = 0;
    rd(8'h1C, b);
    check(a - b == 10, "R5", a - b, 10);

    // R6: periodic, reload 4 gives period 5; reload write takes effect later
    wr(8'h00, 0);
    wr(8'h14, 4);
    wr(8'h10, 4);
    wr(8'h04, 0);
    wr(8'h00, 32'h3);
    wait_irq0(50, n);
    e = 0;
    wr(8'h04, 32'h100); e++;
    while (!irq0 && e < 50) begin cyc(); e++; end
    check(e == 5, "R6", e, 5);
    e = 0;
    wr(8'h04, 32'h100); e++;
    wr(8'h10, 9); e++;
    while (!irq0 && e < 50) begin cyc(); e++; end
    check(e == 5, "R6", e, 5);
    e = 0;
    wr(8'h04, 32'h100); e++;
    while (!irq0 && e < 50) begin cyc(); e++; end
    check(e == 10, "R6", e, 10);

    // R7: one-shot fires once
    wr(8'h00, 0);
    wr(8'h14, 3);
    wr(8'h04, 0);
    wr(8'h00, 32'h1);
    wait_irq0(50, n);
    check(irq0, "R7", 32'(irq0), 1);
    wr(8'h04, 0);
    idle(50);
    rd(8'h14, a);
    check(!irq0 && a == 0, "R7", {a[30:0], irq0}, 0);
    wr(8'h14, 2);
    wait_irq0(20, n);
    check(irq0, "R7", 32'(irq0), 1);

    // R8: set wins over clear with an expiry on every cycle
    wr(8'h00, 0);
    wr(8'h14, 0);
    wr(8'h10, 0);
    wr(8'h00, 32'h3);
    idle(3);
    wr(8'h04, 0);
    rd(8'h04, a);
    check(a[0] == 1'b1, "R8", a, 1);

    // R8: masked clear keeps written-1 flags
    wr(8'h00, 0);
    wr(8'h1C, 1);
    wr(8'h00, 32'h4);
    idle(4);
    rd(8'h04, a);
    check(a == 32'h101, "R8", a, 32'h101);
    wr(8'h04, 32'h1);
    rd(8'h04, a);
    check(a == 32'h1 && irq0 && !irq1, "R8", a, 32'h1);
    wr(8'h04, 32'h100);
    rd(8'h04, a);
    check(a == 0 && !irq0, "R8", a, 0);
    check(!irq0 && !irq1, "R9", {30'd0, irq1, irq0}, 0);

    idle(5);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule